// File: doc/BRIEF.md
# Gated Synchronized Square-Wave Oscillator

This block generates a square wave from the system clock and starts it on command from an active-low gate input. Every falling edge of the gate restarts the waveform from a fixed phase (high, counter cleared), so the output lines up with an arbitrary, asynchronous gating signal. Holding the gate low gives a continuous wave train. Pulsing it gives keyed bursts, and each burst begins from the same phase.

The length of each half of the wave is set by an unsigned half-period value, counted in system clock cycles. Two outputs are provided. While the oscillator runs they carry the same level. While it is stopped they rest at opposite levels: the first low and the second high. The gate goes through a two-flop synchronizer before its edges are detected. An asynchronous active-low reset, released synchronously inside the block, puts it in the stopped state.

Top module: `gso_osc`

## Requirements
- R1: During reset and after its release, with the gate inactive (high), `wave_a` is 0 and `wave_b` is 1.
- R2: If `gate_n` is driven low before clock edge k, both outputs are still at the stopped levels after edge k+1 and are both 1 after edge k+2.
- R3: While running, the outputs hold each level for exactly `half_period` clock cycles, so the output is high for cycles 0..H-1 after the start, low for H..2H-1, and so on.
- R4: A `half_period` value of 0 behaves exactly like a value of 1, giving a level change on every cycle.
- R5: While the oscillator runs, `wave_a` and `wave_b` are equal on every cycle.
- R6: If `gate_n` is driven high before edge k, the wave continues unchanged through edge k+1, and after edge k+2 `wave_a` is 0 and `wave_b` is 1.
- R7: With the gate held low, the wave keeps toggling with the same period for as long as the gate stays low.
- R8: Each new gate falling edge restarts the wave in its high phase with a full high half-period, whichever phase the previous burst ended in.
- R9: While stopped, changes on `half_period` have no effect on the outputs, which stay at `wave_a` = 0 and `wave_b` = 1.
- R10: Asserting `rst_n` low while running forces the outputs to the stopped levels at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| gate_n | input | 1 | Active-low gate, asynchronous to `clk`; its falling edge starts the wave and its rising edge stops it |
| half_period | input | HP_W (16) | Cycles per half of the wave; 0 acts as 1 |
| wave_a | output | 1 | First output: follows the wave while running, 0 while stopped |
| wave_b | output | 1 | Second output: follows the wave while running, 1 while stopped |

## Verification
A gate change made before edge k goes through two synchronizer flops and one edge-detect flop, so its effect shows at the outputs only after edge k+2. The bench drives the gate on the falling clock edge. It checks the still-unchanged value after edge k+1 and the new value after edge k+2, sampling 1 ns after each rising edge. From the start edge on, the expected level at cycle t is high when floor(t / max(H,1)) is even. The bench checks this on every cycle of each burst, together with the equality of the two outputs. An asynchronous reset is checked 1 ns after it is applied, before any clock edge.

// File: rtl/gso_pkg.sv
`timescale 1ns/1ps
package gso_pkg;

  // Run state of the oscillator controller.
  typedef enum logic {
    GSO_IDLE = 1'b0,
    GSO_RUN  = 1'b1
  } gso_state_e;

  // Levels the output pair rests at while stopped.
  localparam logic GSO_IDLE_A = 1'b0;
  localparam logic GSO_IDLE_B = 1'b1;

endpackage

// File: rtl/gso_gate_sync.sv
`timescale 1ns/1ps
// Synchronizes the asynchronous active-low gate and flags its edges.
module gso_gate_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_n,
  output logic gate_fall,
  output logic gate_rise
);

  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;
  logic              sync_out;

  // The chain shifts gate_n in at bit 0. Its reset value is the inactive
  // level, so leaving reset is not seen as an edge.
  always_comb begin
    sync_d = {sync_q[STAGES-2:0], gate_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      last_q <= sync_q[TOP];
    end
  end

  assign sync_out  = sync_q[TOP];
  assign gate_fall = last_q & ~sync_out;
  assign gate_rise = ~last_q & sync_out;

endmodule

// File: rtl/gso_ctrl.sv
`timescale 1ns/1ps
// Run/stop controller driven by the gate edges.
module gso_ctrl
  import gso_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic gate_fall,
  input  logic gate_rise,
  output logic run
);

  gso_state_e state_q;
  gso_state_e state_d;
  logic       state_en;

  always_comb begin
    state_d  = state_q;
    state_en = gate_fall | gate_rise;
    if (gate_fall) begin
      state_d = GSO_RUN;
    end else if (gate_rise) begin
      state_d = GSO_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GSO_IDLE;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  assign run = (state_q == GSO_RUN);

endmodule

// File: rtl/gso_phase_cnt.sv
`timescale 1ns/1ps
// Half-period counter and wave level; restart forces the high phase.
module gso_phase_cnt #(
  parameter int HP_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            run,
  input  logic [HP_W-1:0] half_period,
  output logic            level
);

  localparam logic [HP_W-1:0] CNT_ZERO = '0;
  localparam logic [HP_W-1:0] CNT_ONE  = {{(HP_W-1){1'b0}}, 1'b1};

  logic [HP_W-1:0] cnt_q;
  logic [HP_W-1:0] cnt_d;
  logic            level_q;
  logic            level_d;
  logic            upd_en;
  logic [HP_W-1:0] term_c;
  logic            wrap_c;

  // The last count of a half; a setting of 0 gives the same value as 1.
  always_comb begin
    if (half_period == CNT_ZERO) begin
      term_c = CNT_ZERO;
    end else begin
      term_c = half_period - CNT_ONE;
    end
    // The compare uses >=, so a smaller setting made mid-half ends it at once.
    wrap_c = (cnt_q >= term_c);
  end

  always_comb begin
    cnt_d   = cnt_q;
    level_d = level_q;
    upd_en  = restart | run | (cnt_q != CNT_ZERO) | level_q;
    if (restart) begin
      cnt_d   = CNT_ZERO;
      level_d = 1'b1;
    end else if (run) begin
      if (wrap_c) begin
        cnt_d   = CNT_ZERO;
        level_d = ~level_q;
      end else begin
        cnt_d   = cnt_q + CNT_ONE;
      end
    end else begin
      cnt_d   = CNT_ZERO;
      level_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= CNT_ZERO;
      level_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q   <= cnt_d;
      level_q <= level_d;
    end
  end

  assign level = level_q;

endmodule

// File: rtl/gso_out_pair.sv
`timescale 1ns/1ps
// Output pair: both follow the level while running, complementary rest otherwise.
module gso_out_pair
  import gso_pkg::*;
(
  input  logic run,
  input  logic level,
  output logic wave_a,
  output logic wave_b
);

  always_comb begin
    if (run) begin
      wave_a = level;
      wave_b = level;
    end else begin
      wave_a = GSO_IDLE_A;
      wave_b = GSO_IDLE_B;
    end
  end

endmodule

// File: rtl/gso_osc.sv
`timescale 1ns/1ps
// Top: gated, phase-restarting square-wave oscillator.
module gso_osc #(
  parameter int HP_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gate_n,
  input  logic [HP_W-1:0] half_period,
  output logic            wave_a,
  output logic            wave_b
);

  logic rst_meta_q;
  logic rst_sync_q;
  logic rst_n_int;
  logic gate_fall;
  logic gate_rise;
  logic run_q;
  logic level;

  // The reset asserts at once and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign rst_n_int = rst_sync_q;

  gso_gate_sync #(
    .STAGES (SYNC_STAGES)
  ) u_gate_sync (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .gate_n    (gate_n),
    .gate_fall (gate_fall),
    .gate_rise (gate_rise)
  );

  gso_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .gate_fall (gate_fall),
    .gate_rise (gate_rise),
    .run       (run_q)
  );

  gso_phase_cnt #(
    .HP_W (HP_W)
  ) u_phase_cnt (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .restart     (gate_fall),
    .run         (run_q),
    .half_period (half_period),
    .level       (level)
  );

  gso_out_pair u_out_pair (
    .run    (run_q),
    .level  (level),
    .wave_a (wave_a),
    .wave_b (wave_b)
  );

endmodule

// File: rtl/gso_osc_chk.sv
`timescale 1ns/1ps
// Property checker attached to gso_osc.
module gso_osc_chk #(
  parameter int HP_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            gate_fall,
  input logic            gate_rise,
  input logic            run,
  input logic [HP_W-1:0] half_period,
  input logic            wave_a,
  input logic            wave_b
);

  logic [HP_W:0]   len_q;
  logic            prev_a_q;
  logic            prev_run_q;
  logic [HP_W-1:0] prev_hp_q;
  logic            same_c;
  logic [HP_W:0]   eff_c;

  // A streak continues while running, the level is unchanged and the setting is stable.
  assign same_c = run & prev_run_q & (wave_a == prev_a_q) & (half_period == prev_hp_q);
  assign eff_c  = (half_period == '0) ? {{HP_W{1'b0}}, 1'b1} : {1'b0, half_period};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q      <= '0;
      prev_a_q   <= 1'b0;
      prev_run_q <= 1'b0;
      prev_hp_q  <= '0;
    end else begin
      prev_a_q   <= wave_a;
      prev_run_q <= run;
      prev_hp_q  <= half_period;
      len_q      <= same_c ? len_q + 1'b1 : {{HP_W{1'b0}}, 1'b1};
    end
  end

  AST_IDLE_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_a != wave_b) |-> (!wave_a && wave_b)); // R9

  AST_RUN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (wave_a == wave_b)); // R5

  AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    gate_fall |=> (run && wave_a && wave_b)); // R2

  AST_STOP_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    gate_rise |=> (!run && !wave_a && wave_b)); // R6

  AST_HALF_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    same_c |-> ((len_q + 1'b1) <= eff_c)); // R3

endmodule

bind gso_osc gso_osc_chk #(
  .HP_W (HP_W)
) u_gso_osc_chk (
  .clk         (clk),
  .rst_n       (rst_n_int),
  .gate_fall   (gate_fall),
  .gate_rise   (gate_rise),
  .run         (run_q),
  .half_period (half_period),
  .wave_a      (wave_a),
  .wave_b      (wave_b)
);

// File: tb/test_gso_osc.sv
`timescale 1ns/1ps
module test_gso_osc;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gate_n = 1'b1;
  logic [15:0] half_period = 16'd4;
  logic        wave_a;
  logic        wave_b;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  gso_osc i_gso_osc (
    .clk         (clk),
    .rst_n       (rst_n),
    .gate_n      (gate_n),
    .half_period (half_period),
    .wave_a      (wave_a),
    .wave_b      (wave_b)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic bit exp_wave(input int t, input int eff);
    return ((t / eff) % 2) == 0;
  endfunction

  task automatic chk_idle(input string req);
    chk(wave_a == 1'b0, req, wave_a, 0);
    chk(wave_b == 1'b1, req, wave_b, 1);
  endtask

  // One burst: start, check every cycle, stop, check the stop latency.
  task automatic run_burst(input int hp, input int n, input string shape_req,
                           input string start_req);
    int eff;
    eff = (hp == 0) ? 1 : hp;
    @(negedge clk);
    half_period = hp[15:0];
    gate_n = 1'b0;
    step();                       // edge k
    step();                       // edge k+1: not started yet (R2)
    chk_idle("R2");
    for (int t = 0; t < n; t++) begin
      step();
      chk(wave_a == exp_wave(t, eff), (t == 0) ? start_req : shape_req,
          wave_a, exp_wave(t, eff));
      chk(wave_b == wave_a, "R5", wave_b, wave_a);
    end
    @(negedge clk);
    gate_n = 1'b1;
    step();                       // edge k: wave at t=n
    step();                       // edge k+1: wave at t=n+1, still running (R6)
    chk(wave_a == exp_wave(n + 1, eff), "R6", wave_a, exp_wave(n + 1, eff));
    chk(wave_b == exp_wave(n + 1, eff), "R6", wave_b, exp_wave(n + 1, eff));
    step();                       // edge k+2: stopped (R6)
    chk_idle("R6");
  endtask

  task automatic t_reset();
    rst_n  = 1'b0;
    gate_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk_idle("R1");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step();
    chk_idle("R1");
  endtask

  task automatic t_idle_ignore();
    int vals[4] = '{0, 1, 7, 65535};
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      half_period = vals[i][15:0];
      step();
      chk_idle("R9");
      step();
      chk_idle("R9");
    end
  endtask

  task automatic t_reset_mid_run();
    @(negedge clk);
    half_period = 16'd8;
    gate_n = 1'b0;
    repeat (4) step();
    chk(wave_a == 1'b1, "R10", wave_a, 1);
    @(negedge clk);
    rst_n  = 1'b0;
    gate_n = 1'b1;
    #1;
    chk_idle("R10");
    repeat (2) step();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step();
    chk_idle("R1");
  endtask

  initial begin
    t_reset();
    run_burst(3, 20, "R3", "R2");
    run_burst(1, 10, "R3", "R2");
    run_burst(0, 10, "R4", "R4");
    run_burst(5, 200, "R7", "R2");
    run_burst(6, 9, "R8", "R8");   // ends in a low phase
    run_burst(6, 4, "R8", "R8");   // ends in a high phase
    run_burst(2, 5, "R8", "R8");
    t_idle_ignore();
    run_burst(2, 8, "R3", "R2");
    t_reset_mid_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule